// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This controller decides which of three oscillators drives the system master clock. It sets the source-select and prescaler codes for an external glitch-free clock mux. After reset it selects the high-speed internal RC oscillator with a divide-by-8 prescaler. It holds the master clock gated off until that oscillator reports stable.

Software requests a new source in two steps. It arms a switch-enable bit, and it writes an 8-bit code that names the target oscillator. The controller then turns on the target oscillator's enable and raises a busy flag. The old source keeps driving the system while the target stabilises. When the synchronised ready of the target is seen and switch-enable is armed, the controller commits the change. The code is copied into the status register, the select output follows it, and the previous oscillator is switched off unless a keep-on input holds it. The low-speed internal source can be barred as master by an option input.

Top module: `mclk_switch_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `status_code` is 0xE1, `mclk_sel` is 0, `mclk_div` is 3 (divide by 8), `osc_en` is 3'b001, and `busy`, `sw_en` and `mclk_release` are all 0.
- R2: `mclk_release` rises exactly three clock edges after the selected source's asynchronous ready goes high (two synchroniser stages plus one register). It then stays high.
- R3: Source codes are 0xE1 for the high-speed internal RC (index 0), 0xD2 for the low-speed internal RC (index 1) and 0xB4 for the high-speed external oscillator (index 2). A valid code written while idle that differs from the current status sets `busy` and `osc_en[index]` at the next edge.
- R4: While `busy` is high and no commit occurs, `status_code` and `mclk_sel` keep their old values.
- R5: A commit occurs on the edge when `busy`, `sw_en` and the synchronised ready of the target are all high. At that edge `status_code` takes the target code and `mclk_sel` takes its index. At the same edge `busy` and `sw_en` clear and `mclk_div` becomes 0 (divide by 1). Seen from the asynchronous ready input, the change appears on the third edge.
- R6: On commit the internal enable of the previous source clears. Each bit of `osc_en` is that internal enable ORed with the matching `osc_keep` bit.
- R7: A code other than the three valid ones is ignored: `busy`, `sw_en`, `osc_en` and `status_code` stay unchanged.
- R8: While `lsi_allow` is low, a write of 0xD2 is refused: `busy` stays 0 and no enable changes.
- R9: A target write while `busy` is high is ignored. The pending target and all enables stay as they were.
- R10: A write of the code already held in `status_code` completes at once. `sw_en` clears, `busy` stays 0 and `osc_en` is unchanged.
- R11: If `sw_en` is low when the target is accepted, the oscillator starts but the commit waits. The commit happens on the edge after the edge that sets `sw_en`, provided the target is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Write strobe for the switch-enable bit |
| en_wdata | input | 1 | Value written to switch-enable |
| tgt_we | input | 1 | Write strobe for the target source code |
| tgt_code | input | 8 | Target source code |
| lsi_allow | input | 1 | Option bit; low bars the low-speed source as master |
| osc_rdy_async | input | 3 | Asynchronous oscillator ready flags, by source index |
| osc_keep | input | 3 | Forces the matching oscillator enable on |
| sw_en | output | 1 | Switch-enable bit |
| busy | output | 1 | Switch in progress |
| status_code | output | 8 | Code of the active master source |
| osc_en | output | 3 | Oscillator enables, by source index |
| mclk_sel | output | 2 | Source index for the clock mux |
| mclk_div | output | 2 | Prescaler code, log2 of the divide ratio |
| mclk_release | output | 1 | Master clock ungated |

## Verification
The switch is tried with the target write issued after switch-enable is armed, and again with switch-enable armed only after the target is ready. These two runs separate commit timing driven by the ready synchroniser from commit timing driven by the software bit. Writes of an unknown code, a barred low-speed request, a write during busy and a write of the current code each show that one filter leaves state untouched. Switching away from a source with and without its keep-on input distinguishes the internal enable drop from the forced-on path.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int N_SRC  = 3;
  localparam int CODE_W = 8;
  localparam int IDX_W  = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam code_t CODE_HSI = 8'hE1;
  localparam code_t CODE_LSI = 8'hD2;
  localparam code_t CODE_HSE = 8'hB4;

  localparam idx_t IDX_HSI = 2'd0;
  localparam idx_t IDX_LSI = 2'd1;
  localparam idx_t IDX_HSE = 2'd2;

  function automatic logic code_valid(code_t c);
    return (c == CODE_HSI) || (c == CODE_LSI) || (c == CODE_HSE);
  endfunction

  function automatic idx_t code_to_idx(code_t c);
    case (c)
      CODE_LSI: return IDX_LSI;
      CODE_HSE: return IDX_HSE;
      default:  return IDX_HSI;
    endcase
  endfunction

  function automatic code_t idx_to_code(idx_t i);
    case (i)
      IDX_LSI: return CODE_LSI;
      IDX_HSE: return CODE_HSE;
      default: return CODE_HSI;
    endcase
  endfunction
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mcs_req_filter.sv
module mcs_req_filter
  import mcs_pkg::*;
(
  input  logic  tgt_we,
  input  code_t tgt_code,
  input  logic  busy,
  input  idx_t  stat_idx,
  input  logic  lsi_allow,
  output logic  accept_evt,
  output logic  same_evt
);
  logic usable;

  always_comb begin
    usable     = tgt_we && !busy && code_valid(tgt_code) &&
                 !((tgt_code == CODE_LSI) && !lsi_allow);
    same_evt   = usable && (code_to_idx(tgt_code) == stat_idx);
    accept_evt = usable && (code_to_idx(tgt_code) != stat_idx);
  end
endmodule

// File: rtl/mcs_fsm.sv
module mcs_fsm
  import mcs_pkg::*;
#(
  parameter int             DIV_W     = 2,
  parameter logic [DIV_W-1:0] RESET_DIV = 2'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             accept_evt,
  input  logic             same_evt,
  input  code_t            tgt_code,
  input  logic [N_SRC-1:0] rdy_s,
  output logic             busy,
  output logic             sw_en,
  output idx_t             tgt_idx,
  output idx_t             stat_idx,
  output logic [N_SRC-1:0] en_q,
  output logic [DIV_W-1:0] div_q,
  output logic             release_q,
  output logic             commit_evt
);
  assign commit_evt = busy && sw_en && rdy_s[tgt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sw_en     <= 1'b0;
      tgt_idx   <= IDX_HSI;
      stat_idx  <= IDX_HSI;
      en_q      <= N_SRC'(1) << IDX_HSI;
      div_q     <= RESET_DIV;
      release_q <= 1'b0;
    end else begin
      if (rdy_s[stat_idx]) release_q <= 1'b1;

      if (commit_evt || same_evt) sw_en <= 1'b0;
      else if (en_wr)             sw_en <= en_wdata;

      if (accept_evt) begin
        busy              <= 1'b1;
        tgt_idx           <= code_to_idx(tgt_code);
        en_q[code_to_idx(tgt_code)] <= 1'b1;
      end else if (commit_evt) begin
        busy           <= 1'b0;
        stat_idx       <= tgt_idx;
        en_q[stat_idx] <= 1'b0;
        div_q          <= '0;
      end
    end
  end
endmodule

// File: rtl/mclk_switch_ctrl.sv
module mclk_switch_ctrl
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2,
  parameter int RESET_DIV   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             tgt_we,
  input  logic [7:0]       tgt_code,
  input  logic             lsi_allow,
  input  logic [2:0]       osc_rdy_async,
  input  logic [2:0]       osc_keep,
  output logic             sw_en,
  output logic             busy,
  output logic [7:0]       status_code,
  output logic [2:0]       osc_en,
  output logic [1:0]       mclk_sel,
  output logic [DIV_W-1:0] mclk_div,
  output logic             mclk_release
);
  logic [N_SRC-1:0] rdy_s;
  logic [N_SRC-1:0] en_q;
  logic             accept_evt;
  logic             same_evt;
  logic             commit_evt;
  idx_t             tgt_idx;
  idx_t             stat_idx;

  mcs_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (osc_rdy_async),
    .q_sync  (rdy_s)
  );

  mcs_req_filter u_filt (
    .tgt_we     (tgt_we),
    .tgt_code   (tgt_code),
    .busy       (busy),
    .stat_idx   (stat_idx),
    .lsi_allow  (lsi_allow),
    .accept_evt (accept_evt),
    .same_evt   (same_evt)
  );

  mcs_fsm #(.DIV_W(DIV_W), .RESET_DIV(DIV_W'(RESET_DIV))) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .accept_evt (accept_evt),
    .same_evt   (same_evt),
    .tgt_code   (tgt_code),
    .rdy_s      (rdy_s),
    .busy       (busy),
    .sw_en      (sw_en),
    .tgt_idx    (tgt_idx),
    .stat_idx   (stat_idx),
    .en_q       (en_q),
    .div_q      (mclk_div),
    .release_q  (mclk_release),
    .commit_evt (commit_evt)
  );

  assign osc_en      = en_q | osc_keep;
  assign status_code = idx_to_code(stat_idx);
  assign mclk_sel    = stat_idx;
endmodule

// File: rtl/mcs_chk.sv
module mcs_chk
  import mcs_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tgt_we,
  input logic [7:0]       tgt_code,
  input logic             lsi_allow,
  input logic             busy,
  input logic             sw_en,
  input logic [7:0]       status_code,
  input logic [2:0]       osc_en,
  input logic [DIV_W-1:0] mclk_div,
  input logic             mclk_release,
  input logic             accept_evt,
  input logic             same_evt,
  input logic             commit_evt,
  input logic [1:0]       tgt_idx
);
  // R2
  release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_release |=> mclk_release);

  // R3
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (busy && osc_en[tgt_idx]));

  // R4
  old_source_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit_evt) |=> $stable(status_code));

  // R5
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (!busy && !sw_en && mclk_div == '0));

  // R7
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tgt_we && !code_valid(tgt_code)) |=> (!busy && $stable(status_code)));

  // R8
  lsi_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tgt_we && tgt_code == CODE_LSI && !lsi_allow) |=> !busy);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tgt_we) |=> $stable(tgt_idx));

  // R10
  same_code_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    same_evt |=> (!busy && !sw_en));

  // R11
  commit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sw_en) |-> !commit_evt);
endmodule

bind mclk_switch_ctrl mcs_chk #(.DIV_W(DIV_W)) u_mcs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tgt_we       (tgt_we),
  .tgt_code     (tgt_code),
  .lsi_allow    (lsi_allow),
  .busy         (busy),
  .sw_en        (sw_en),
  .status_code  (status_code),
  .osc_en       (osc_en),
  .mclk_div     (mclk_div),
  .mclk_release (mclk_release),
  .accept_evt   (accept_evt),
  .same_evt     (same_evt),
  .commit_evt   (commit_evt),
  .tgt_idx      (tgt_idx)
);

// File: tb/test_mclk_switch_ctrl.sv
module test_mclk_switch_ctrl;
  localparam int CLK_P = 10;
  localparam int DLY [3] = '{6, 4, 5};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_wr = 1'b0, en_wdata = 1'b0, tgt_we = 1'b0, lsi_allow = 1'b1;
  logic [7:0] tgt_code = 8'h00;
  logic [2:0] rdy_a = 3'b000, osc_keep = 3'b000;
  logic       sw_en, busy, mclk_release;
  logic [7:0] status_code;
  logic [2:0] osc_en;
  logic [1:0] mclk_sel, mclk_div;
  int         n_chk = 0, n_bad = 0;
  int         cnt [3] = '{0, 0, 0};

  mclk_switch_ctrl i_mclk_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .tgt_we(tgt_we), .tgt_code(tgt_code), .lsi_allow(lsi_allow),
    .osc_rdy_async(rdy_a), .osc_keep(osc_keep), .sw_en(sw_en), .busy(busy),
    .status_code(status_code), .osc_en(osc_en), .mclk_sel(mclk_sel),
    .mclk_div(mclk_div), .mclk_release(mclk_release));

  always #(CLK_P/2) clk = ~clk;

  // oscillator stubs: ready follows enable after a per-source delay
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (!rst_n || !osc_en[i]) begin
        cnt[i] <= 0; rdy_a[i] <= 1'b0;
      end else if (cnt[i] >= DLY[i]) rdy_a[i] <= 1'b1;
      else cnt[i] <= cnt[i] + 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr_en(logic v);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic wr_tgt(logic [7:0] c);
    tgt_we = 1'b1; tgt_code = c;
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "status", status_code, 8'hE1);
    chk("R1", "sel", mclk_sel, 0);
    chk("R1", "div", mclk_div, 3);
    chk("R1", "osc_en", osc_en, 3'b001);
    chk("R1", "busy", busy, 0);
    chk("R1", "sw_en", sw_en, 0);
    chk("R1", "release", mclk_release, 0);
  endtask

  task automatic t_release();
    wait (rdy_a[0]);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2", "release before 3rd edge", mclk_release, 0);
    @(negedge clk);
    chk("R2", "release at 3rd edge", mclk_release, 1);
    repeat (3) @(negedge clk);
    chk("R2", "release sticky", mclk_release, 1);
  endtask

  // switch to the external source with enable armed first
  task automatic t_switch_hse();
    wr_en(1'b1);
    wr_tgt(8'hB4);
    chk("R3", "busy", busy, 1);
    chk("R3", "osc_en", osc_en, 3'b101);
    chk("R4", "status held", status_code, 8'hE1);
    wait (rdy_a[2]);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4", "status before commit", status_code, 8'hE1);
    chk("R4", "sel before commit", mclk_sel, 0);
    @(negedge clk);
    chk("R5", "status", status_code, 8'hB4);
    chk("R5", "sel", mclk_sel, 2);
    chk("R5", "busy", busy, 0);
    chk("R5", "sw_en", sw_en, 0);
    chk("R5", "div", mclk_div, 0);
    chk("R6", "old enable dropped", osc_en, 3'b100);
  endtask

  task automatic t_invalid();
    wr_en(1'b1);
    wr_tgt(8'h55);
    @(negedge clk);
    chk("R7", "busy", busy, 0);
    chk("R7", "sw_en", sw_en, 1);
    chk("R7", "osc_en", osc_en, 3'b100);
    chk("R7", "status", status_code, 8'hB4);
  endtask

  task automatic t_lsi_refused();
    lsi_allow = 1'b0;
    wr_tgt(8'hD2);
    @(negedge clk);
    chk("R8", "busy", busy, 0);
    chk("R8", "osc_en", osc_en, 3'b100);
    chk("R8", "status", status_code, 8'hB4);
    lsi_allow = 1'b1;
  endtask

  // accept with enable clear, busy write, late enable, keep-on
  task automatic t_wait_enable();
    wr_en(1'b0);
    osc_keep = 3'b100;
    wr_tgt(8'hD2);
    chk("R11", "busy", busy, 1);
    chk("R11", "lsi started", osc_en, 3'b110);
    wr_tgt(8'hE1);
    chk("R9", "no hsi enable", osc_en, 3'b110);
    wait (rdy_a[1]);
    repeat (6) @(negedge clk);
    chk("R11", "still waiting", status_code, 8'hB4);
    chk("R11", "still busy", busy, 1);
    wr_en(1'b1);
    chk("R11", "not yet committed", status_code, 8'hB4);
    @(negedge clk);
    chk("R11", "committed", status_code, 8'hD2);
    chk("R9", "target kept", mclk_sel, 1);
    chk("R6", "keep holds old on", osc_en, 3'b110);
    osc_keep = 3'b000;
    #1;
    chk("R6", "keep released", osc_en, 3'b010);
  endtask

  task automatic t_same();
    @(negedge clk);
    wr_en(1'b1);
    wr_tgt(8'hD2);
    chk("R10", "sw_en cleared", sw_en, 0);
    chk("R10", "busy", busy, 0);
    chk("R10", "osc_en", osc_en, 3'b010);
    chk("R10", "status", status_code, 8'hD2);
  endtask

  task automatic t_back_hsi();
    wr_en(1'b1);
    wr_tgt(8'hE1);
    chk("R3", "hsi started", osc_en, 3'b011);
    wait (rdy_a[0]);
    repeat (3) @(negedge clk);
    chk("R5", "status hsi", status_code, 8'hE1);
    chk("R5", "sel hsi", mclk_sel, 0);
    chk("R6", "lsi dropped", osc_en, 3'b001);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_release();
    t_switch_hse();
    t_invalid();
    t_lsi_refused();
    t_wait_enable();
    t_same();
    t_back_hsi();
    repeat (2) @(negedge clk);
    report();
  end
endmodule